// File: doc/BRIEF.md
# Packed-Word Palette Loader

The block fills a colour lookup table whose entries each hold an 8-bit red, green and blue component. Software first names a starting entry on an address channel; the index is forced down to a multiple of four. It then sends 32-bit data words in which the component bytes of four neighbouring entries are packed back to back. Three words carry one aligned group of four entries, so a single word can end one entry and begin the next. The loader splits each word into its bytes and tracks where it stands inside the group. It keeps unfinished entries in a staging register and writes an entry into the table only when its last component has arrived.

Both input channels use valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high, and the sender must hold its valid and data steady until then. Ready is low in three cases: while the table is cleared after reset, for one cycle after the last word of a group (the word that completes two entries needs a second table write), and on the data channel whenever the address channel is presenting a request. When a group is finished the loader moves on to the next aligned group by itself, so a continuous stream of words fills consecutive groups. Two read ports, one for pixel lookup and one for read-back, each return a stored colour one clock after an index is given.

Top module: `palette_loader`

## Requirements
- R1: After reset, aw_ready and wd_ready stay low for exactly ENTRIES clock cycles while the table is cleared. From then on every entry reads as zero until it is loaded.
- R2: An accepted address request sets the group base to aw_idx with its two low bits cleared and restarts the byte phase at the group's first word. Any components staged from an unfinished group are dropped.
- R3: Bytes are taken from each data word most significant first (bits 31:24, then 23:16, 15:8, 7:0). Across the three words of a group they form red, green, blue for entry base, then base+1, base+2 and base+3.
- R4: An entry is written only after all three of its components have arrived. After the first word only entry base has changed, and after the second word only base and base+1 have changed.
- R5: In the cycle after the third word of a group is accepted, both aw_ready and wd_ready are low while entry base+3 is written. Ready returns in the following cycle.
- R6: After the third word the base moves to the next aligned group without a new address request. The base wraps from the group at ENTRIES-4 to the group at 0.
- R7: lk_rgb gives {red[23:16], green[15:8], blue[7:0]} of entry lk_idx one clock after lk_idx is applied. If that entry is written on the same edge, the old value is returned.
- R8: A cycle with rb_req high returns entry rb_idx on rb_rgb, with rb_ack high, in the next cycle. rb_ack is low in a cycle that follows no request.
- R9: While aw_valid is high, wd_ready is low, so the address request is served first and the data word waits.
- R10: Loading a group that already holds data overwrites all four of its entries with the new colours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Address request valid |
| aw_ready | output | 1 | Address channel can accept |
| aw_idx | input | IDX_W | Requested starting entry (low two bits ignored) |
| wd_valid | input | 1 | Data word valid |
| wd_ready | output | 1 | Data channel can accept |
| wd_data | input | 4*CW | Packed component bytes, first byte in the top lane |
| lk_idx | input | IDX_W | Pixel index for lookup |
| lk_rgb | output | 3*CW | Colour of lk_idx, one cycle later |
| rb_req | input | 1 | Read-back request |
| rb_idx | input | IDX_W | Entry to read back |
| rb_ack | output | 1 | Read-back data valid |
| rb_rgb | output | 3*CW | Read-back colour |

## Verification
The bench uses the default parameters, ENTRIES=256 and CW=8, so the full table is in play. The 256-cycle stall after reset can be counted edge by edge. Starting at entry 252 and streaming two groups without a new address request reaches the wrap from the last group to group 0. At this size, checking the neighbours of every loaded group shows that words never spill outside their aligned block.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Position of the next data word inside an aligned group of four entries.
  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_THIRD  = 2'd2
  } grp_phase_e;

  localparam int unsigned GROUP_ENTRIES = 4;
  localparam int unsigned LANES         = 4;
  localparam int unsigned COMPONENTS    = 3;
endpackage

// File: rtl/pal_group_ptr.sv
module pal_group_ptr #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             step,
  output logic [IDX_W-1:0] base
);
  localparam logic [IDX_W-1:0] LAST_BASE = IDX_W'(ENTRIES - int'(pal_pkg::GROUP_ENTRIES));
  localparam logic [IDX_W-1:0] GRP_STEP  = IDX_W'(pal_pkg::GROUP_ENTRIES);
  localparam logic [IDX_W-1:0] ALIGN_MSK = ~IDX_W'(pal_pkg::GROUP_ENTRIES - 1);

  // R2 alignment, R6 advance and wrap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
    end else if (set) begin
      base <= set_idx & ALIGN_MSK;
    end else if (step) begin
      base <= (base == LAST_BASE) ? '0 : base + GRP_STEP;
    end
  end
endmodule

// File: rtl/pal_unpacker.sv
module pal_unpacker
  import pal_pkg::*;
#(
  parameter int CW    = 8,
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                take,
  input  logic [4*CW-1:0]     word,
  input  logic [IDX_W-1:0]    base,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [3*CW-1:0]     wr_rgb,
  output logic                hold,
  output logic                group_done,
  output grp_phase_e          phase
);
  localparam int WW = int'(LANES) * CW;

  logic [CW-1:0]    lane [LANES];
  logic [CW-1:0]    stg_a, stg_b;
  logic [3*CW-1:0]  pend_rgb;
  logic [IDX_W-1:0] pend_idx;

  // R3: lane 0 is the most significant byte, consumed first
  for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
    assign lane[j] = word[WW-1-j*CW -: CW];
  end

  // R4: an entry is written only once its blue byte is present
  always_comb begin
    wr_en      = 1'b0;
    wr_idx     = base;
    wr_rgb     = '0;
    group_done = 1'b0;
    if (hold) begin
      wr_en  = 1'b1;
      wr_idx = pend_idx;
      wr_rgb = pend_rgb;
    end else if (take) begin
      unique case (phase)
        PH_FIRST: begin
          wr_en  = 1'b1;
          wr_idx = base;
          wr_rgb = {lane[0], lane[1], lane[2]};
        end
        PH_SECOND: begin
          wr_en  = 1'b1;
          wr_idx = base + IDX_W'(1);
          wr_rgb = {stg_a, lane[0], lane[1]};
        end
        PH_THIRD: begin
          wr_en      = 1'b1;
          wr_idx     = base + IDX_W'(2);
          wr_rgb     = {stg_a, stg_b, lane[0]};
          group_done = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_FIRST;
      hold     <= 1'b0;
      stg_a    <= '0;
      stg_b    <= '0;
      pend_rgb <= '0;
      pend_idx <= '0;
    end else begin
      // R5: one extra write slot after the word that completes two entries
      hold <= take && (phase == PH_THIRD) && !restart;
      if (restart) begin
        phase <= PH_FIRST;              // R2: staged bytes abandoned
      end else if (take) begin
        unique case (phase)
          PH_FIRST: begin
            stg_a <= lane[3];
            phase <= PH_SECOND;
          end
          PH_SECOND: begin
            stg_a <= lane[2];
            stg_b <= lane[3];
            phase <= PH_THIRD;
          end
          PH_THIRD: begin
            pend_rgb <= {lane[1], lane[2], lane[3]};
            pend_idx <= base + IDX_W'(3);
            phase    <= PH_FIRST;
          end
          default: phase <= PH_FIRST;
        endcase
      end
    end
  end
endmodule

// File: rtl/pal_clear_seq.sv
module pal_clear_seq #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             clearing,
  output logic [IDX_W-1:0] clr_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  // R1: one entry zeroed per cycle after reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
    end else if (clearing) begin
      clr_idx <= clr_idx + IDX_W'(1);
      if (clr_idx == LAST_IDX) clearing <= 1'b0;
    end
  end
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int ENTRIES = 256,
  parameter int DW      = 24,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] lk_addr,
  output logic [DW-1:0]    lk_q,
  input  logic             rb_en,
  input  logic [IDX_W-1:0] rb_addr,
  output logic [DW-1:0]    rb_q
);
  logic [DW-1:0] mem [ENTRIES];

  // R7: reads sample the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    lk_q <= mem[lk_addr];
    if (rb_en) rb_q <= mem[rb_addr];
  end
endmodule

// File: rtl/palette_loader.sv
module palette_loader
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int CW      = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aw_valid,
  output logic             aw_ready,
  input  logic [IDX_W-1:0] aw_idx,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [4*CW-1:0]  wd_data,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [3*CW-1:0]  lk_rgb,
  input  logic             rb_req,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_ack,
  output logic [3*CW-1:0]  rb_rgb
);
  localparam int RGBW = int'(COMPONENTS) * CW;

  logic             clearing;
  logic [IDX_W-1:0] clr_idx;
  logic [IDX_W-1:0] grp_base;
  logic             st_wr_en, drain_hold, group_done;
  logic [IDX_W-1:0] st_wr_idx;
  logic [RGBW-1:0]  st_wr_rgb;
  grp_phase_e       phase;
  logic             addr_go, data_go, chan_free;
  logic             ram_we;
  logic [IDX_W-1:0] ram_waddr;
  logic [RGBW-1:0]  ram_wdata;
  logic [RGBW-1:0]  lk_q, rb_q;
  logic             rd_mask_q, rb_ack_q;

  // R1, R5, R9: channel flow control
  assign chan_free = !clearing && !drain_hold;
  assign aw_ready  = chan_free;
  assign wd_ready  = chan_free && !aw_valid;
  assign addr_go   = aw_valid && aw_ready;
  assign data_go   = wd_valid && wd_ready;

  pal_clear_seq #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_clear (
    .clk      (clk),
    .rst_n    (rst_n),
    .clearing (clearing),
    .clr_idx  (clr_idx)
  );

  pal_group_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (addr_go),
    .set_idx (aw_idx),
    .step    (group_done),
    .base    (grp_base)
  );

  pal_unpacker #(.CW(CW), .IDX_W(IDX_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (addr_go),
    .take       (data_go),
    .word       (wd_data),
    .base       (grp_base),
    .wr_en      (st_wr_en),
    .wr_idx     (st_wr_idx),
    .wr_rgb     (st_wr_rgb),
    .hold       (drain_hold),
    .group_done (group_done),
    .phase      (phase)
  );

  assign ram_we    = clearing || st_wr_en;
  assign ram_waddr = clearing ? clr_idx : st_wr_idx;
  assign ram_wdata = clearing ? '0 : st_wr_rgb;

  pal_ram #(.ENTRIES(ENTRIES), .DW(RGBW), .IDX_W(IDX_W)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .lk_addr (lk_idx),
    .lk_q    (lk_q),
    .rb_en   (rb_req),
    .rb_addr (rb_idx),
    .rb_q    (rb_q)
  );

  // R1: reads issued during the clear sweep report zero
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_mask_q <= 1'b1;
      rb_ack_q  <= 1'b0;
    end else begin
      rd_mask_q <= clearing;
      rb_ack_q  <= rb_req;      // R8
    end
  end

  assign lk_rgb = rd_mask_q ? '0 : lk_q;
  assign rb_rgb = rd_mask_q ? '0 : rb_q;
  assign rb_ack = rb_ack_q;
endmodule

// File: rtl/palette_loader_chk.sv
module palette_loader_chk #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             aw_valid,
  input logic             aw_ready,
  input logic [IDX_W-1:0] aw_idx,
  input logic             wd_valid,
  input logic             wd_ready,
  input logic             rb_req,
  input logic             rb_ack,
  input logic             clearing,
  input logic             hold,
  input logic [1:0]       phase,
  input logic [IDX_W-1:0] base
);
  localparam logic [IDX_W-1:0] LAST_BASE = IDX_W'(ENTRIES - 4);

  p_clear_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> (!aw_ready && !wd_ready));

  p_addr_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready) |=> (phase == 2'd0));

  p_addr_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready) |=> (base == ($past(aw_idx) & ~IDX_W'(3))));

  p_drain_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && wd_ready && phase == 2'd2) |=> (!wd_ready && !aw_ready));

  p_drain_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !hold);

  p_group_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && wd_ready && phase == 2'd2 && base == LAST_BASE) |=> (base == '0));

  p_rb_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req |=> rb_ack);

  p_rb_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_req |=> !rb_ack);

  p_addr_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> !wd_ready);
endmodule

bind palette_loader palette_loader_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .aw_valid (aw_valid),
  .aw_ready (aw_ready),
  .aw_idx   (aw_idx),
  .wd_valid (wd_valid),
  .wd_ready (wd_ready),
  .rb_req   (rb_req),
  .rb_ack   (rb_ack),
  .clearing (clearing),
  .hold     (drain_hold),
  .phase    (phase),
  .base     (grp_base)
);

// File: tb/palette_loader_tb.sv
`timescale 1ns/1ps
module palette_loader_tb;
  localparam int ENTRIES = 256;
  localparam int CW      = 8;
  localparam int IDX_W   = 8;

  typedef logic [23:0] grp_t [4];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aw_valid = 1'b0, wd_valid = 1'b0, rb_req = 1'b0;
  logic aw_ready, wd_ready, rb_ack;
  logic [IDX_W-1:0] aw_idx = '0, lk_idx = '0, rb_idx = '0;
  logic [31:0] wd_data = '0;
  logic [23:0] lk_rgb, rb_rgb;

  int total = 0;
  int bad   = 0;
  logic [23:0] model [ENTRIES];

  always #2.5 clk = ~clk;

  palette_loader #(.ENTRIES(ENTRIES), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_idx(aw_idx),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .lk_idx(lk_idx), .lk_rgb(lk_rgb),
    .rb_req(rb_req), .rb_idx(rb_idx), .rb_ack(rb_ack), .rb_rgb(rb_rgb)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] col(input int i, input int s);
    return {8'(i * 7 + s * 13 + 1), 8'(i ^ (s * 37 + 5)), 8'(255 - i + s * 3)};
  endfunction

  function automatic grp_t mk_grp(input int gbase, input int s);
    grp_t g;
    for (int e = 0; e < 4; e++) g[e] = col(gbase + e, s);
    return g;
  endfunction

  // R3 packing: R,G,B per entry in order, first byte in bits 31:24
  function automatic logic [31:0] grp_word(input grp_t g, input int k);
    logic [7:0] b [12];
    for (int e = 0; e < 4; e++) begin
      b[3*e]   = g[e][23:16];
      b[3*e+1] = g[e][15:8];
      b[3*e+2] = g[e][7:0];
    end
    return {b[4*k], b[4*k+1], b[4*k+2], b[4*k+3]};
  endfunction

  task automatic send_addr(input int idx);
    @(negedge clk);
    aw_valid = 1'b1;
    aw_idx   = IDX_W'(idx);
    #1;
    while (!aw_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    aw_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    wd_valid = 1'b1;
    wd_data  = w;
    #1;
    while (!wd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wd_valid = 1'b0;
  endtask

  task automatic look(input int idx, output logic [23:0] v);
    @(negedge clk);
    lk_idx = IDX_W'(idx);
    @(posedge clk); #1;
    v = lk_rgb;
  endtask

  task automatic chk_entry(input string tag, input int idx);
    logic [23:0] v;
    look(idx % ENTRIES, v);
    chk(tag, {8'h0, v}, {8'h0, model[idx % ENTRIES]});
  endtask

  // three words, then the R5 stall window, then model update
  task automatic load_words(input int gbase, input int s);
    grp_t g;
    g = mk_grp(gbase, s);
    send_word(grp_word(g, 0));
    send_word(grp_word(g, 1));
    send_word(grp_word(g, 2));
    chk("R5 wd_ready low after third word", {31'h0, wd_ready}, 32'h0);
    chk("R5 aw_ready low after third word", {31'h0, aw_ready}, 32'h0);
    @(posedge clk); #1;
    chk("R5 wd_ready back", {31'h0, wd_ready}, 32'h1);
    for (int e = 0; e < 4; e++) model[(gbase + e) % ENTRIES] = g[e];
  endtask

  task automatic t_reset();
    int cyc;
    logic [23:0] v;
    for (int i = 0; i < ENTRIES; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 aw_ready low at reset", {31'h0, aw_ready}, 32'h0);
    chk("R1 wd_ready low at reset", {31'h0, wd_ready}, 32'h0);
    cyc = 0;
    while (!aw_ready && cyc < 1000) begin @(posedge clk); #1; cyc++; end
    chk("R1 clear stall length", cyc, ENTRIES);
    look(0, v);   chk("R1 entry 0 zero", {8'h0, v}, 32'h0);
    look(255, v); chk("R1 entry 255 zero", {8'h0, v}, 32'h0);
  endtask

  task automatic t_group();
    send_addr(8'h13);             // R2: aligns to 0x10
    load_words(8'h10, 1);
    for (int e = 0; e < 4; e++) chk_entry("R3 group entry", 8'h10 + e);
    chk_entry("R2 entry below group untouched", 8'h0F);
    chk_entry("R2 entry above group untouched", 8'h14);
  endtask

  task automatic t_partial();
    grp_t g;
    g = mk_grp(8'h20, 2);
    send_addr(8'h20);
    send_word(grp_word(g, 0));
    model[8'h20] = g[0];
    chk_entry("R4 first entry after word 0", 8'h20);
    chk_entry("R4 second entry unchanged after word 0", 8'h21);
    send_word(grp_word(g, 1));
    model[8'h21] = g[1];
    chk_entry("R4 second entry after word 1", 8'h21);
    chk_entry("R4 third entry unchanged after word 1", 8'h22);
    send_addr(8'h22);             // R2: restart mid-group
    load_words(8'h20, 3);
    for (int e = 0; e < 4; e++) chk_entry("R2 restart reload", 8'h20 + e);
  endtask

  task automatic t_stream();
    send_addr(8'hFC);
    load_words(8'hFC, 4);
    load_words(8'h00, 5);         // R6: no address request between groups
    chk_entry("R6 last entry of top group", 8'hFF);
    chk_entry("R6 first entry of top group", 8'hFC);
    chk_entry("R6 wrapped entry 0", 8'h00);
    chk_entry("R6 wrapped entry 3", 8'h03);
    chk_entry("R6 entry 4 untouched", 8'h04);
  endtask

  task automatic t_same_cycle();
    grp_t g;
    g = mk_grp(8'h40, 6);
    send_addr(8'h40);
    @(negedge clk);
    lk_idx   = 8'h40;
    wd_valid = 1'b1;
    wd_data  = grp_word(g, 0);
    @(posedge clk); #1;
    wd_valid = 1'b0;
    chk("R7 same-edge read returns old", {8'h0, lk_rgb}, {8'h0, model[8'h40]});
    @(posedge clk); #1;
    model[8'h40] = g[0];
    chk("R7 next read returns new", {8'h0, lk_rgb}, {8'h0, g[0]});
  endtask

  task automatic t_prio();
    grp_t g;
    g = mk_grp(8'h50, 7);
    @(negedge clk);
    aw_valid = 1'b1;
    aw_idx   = 8'h51;
    wd_valid = 1'b1;
    wd_data  = grp_word(g, 0);
    #1;
    chk("R9 wd_ready low while aw_valid", {31'h0, wd_ready}, 32'h0);
    @(posedge clk); #1;
    aw_valid = 1'b0;
    while (!wd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    wd_valid = 1'b0;
    send_word(grp_word(g, 1));
    send_word(grp_word(g, 2));
    @(posedge clk); #1;
    for (int e = 0; e < 4; e++) model[8'h50 + e] = g[e];
    for (int e = 0; e < 4; e++) chk_entry("R9 address served first", 8'h50 + e);
  endtask

  task automatic t_reload();
    send_addr(8'h10);
    load_words(8'h10, 9);
    for (int e = 0; e < 4; e++) chk_entry("R10 group overwritten", 8'h10 + e);
  endtask

  task automatic t_readback();
    @(negedge clk);
    rb_req = 1'b1;
    rb_idx = 8'h12;
    @(posedge clk); #1;
    rb_req = 1'b0;
    chk("R8 rb_ack after request", {31'h0, rb_ack}, 32'h1);
    chk("R8 read-back colour", {8'h0, rb_rgb}, {8'h0, model[8'h12]});
    @(posedge clk); #1;
    chk("R8 rb_ack idle", {31'h0, rb_ack}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_group();
    t_partial();
    t_stream();
    t_same_cycle();
    t_prio();
    t_reload();
    t_readback();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule